// File: doc/BRIEF.md
# Banked Address Decoder with Wait-State Request

This block sits beside a 16-bit-address CPU that puts its bank byte on the data bus during the low phase of the phase-2 clock. A latch on the low three data bits holds that bank number through the high phase. The three bank bits and the 16-bit address together cover a 512 KB space.

The block decodes that space into three selects: RAM, I/O and ROM. I/O and ROM exist only when the bank number is zero, so banks one to seven are plain RAM with no copies of the slow devices. An access to I/O or ROM raises a wait-state request, which an external clock-stretch circuit uses. RAM read and write strobes are gated by phase-2 high. When the CPU marks a cycle as carrying no valid address, all outputs are quiet.

Top module: `banked_addr_decoder`

## Requirements
- R1: While phi2_i is low, bank_o follows data_i[2:0] with no clock delay.
- R2: While phi2_i is high, bank_o holds the value data_i[2:0] had at the rising edge of phi2_i, even if data_i changes during the high phase.
- R3: While rst_ni is low, the held bank value is 0, so bank_o reads 0 during phi2_i high.
- R4: In bank 0, any valid address whose bits 15 and 14 are not both 1 asserts ram_sel_o only.
- R5: In bank 0, valid addresses $C000-$CFFF (bits 15:14 = 11, bits 13:12 = 00, bit 11 ignored) assert io_sel_o only. The $C800-$CFFF half mirrors $C000-$C7FF.
- R6: In bank 0, valid addresses $D000-$FFFF assert rom_sel_o only.
- R7: In banks 1 to 7, every valid address asserts ram_sel_o only. wait_req_o stays low in these banks.
- R8: data_i[7:3] has no effect. A bank byte of $08 decodes as bank 0.
- R9: wait_req_o is 1 exactly when the address is valid, the bank is 0, and address bits 15 and 14 are both 1.
- R10: A cycle is valid when vda_i or vpa_i is 1. When both are 0, all selects, both strobes and wait_req_o are 0.
- R11: ram_rd_o = ram_sel_o & phi2_i & rwb_i, and ram_wr_o = ram_sel_o & phi2_i & !rwb_i. Both strobes are 0 while phi2_i is low.
- R12: At most one select is active at any time. wait_req_o stays constant through the phi2_i-high phase while the address is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| phi2_i | input | 1 | Phase-2 CPU clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the bank hold register |
| data_i | input | 8 | CPU data bus; carries the bank byte while phi2_i is low |
| addr_i | input | 16 | CPU address A15-A0 |
| vda_i | input | 1 | Valid data address qualifier |
| vpa_i | input | 1 | Valid program address qualifier |
| rwb_i | input | 1 | 1 for read, 0 for write |
| bank_o | output | 3 | Extended address A18-A16 |
| ram_sel_o | output | 1 | RAM select |
| io_sel_o | output | 1 | I/O select |
| rom_sel_o | output | 1 | ROM select |
| ram_rd_o | output | 1 | RAM read strobe, high-phase qualified |
| ram_wr_o | output | 1 | RAM write strobe, high-phase qualified |
| wait_req_o | output | 1 | Wait-state request for slow devices |

## Verification
The assertions run on every phase-2 edge. They check four things:
- the selects are mutually exclusive;
- an invalid cycle is quiet;
- the held bank matches the byte present at the rising edge;
- banks 1 to 7 decode only to RAM, a wait request implies a slow select, and the strobes are low during the low phase.

Some behaviours only the directed scenarios can show:
- the exact region boundaries and the I/O mirror;
- that the upper bank-byte bits are ignored;
- that the latch is transparent in the low phase;
- that reset clears the bank;
- that the wait request stays steady across the high phase.

// File: rtl/bank_dec_pkg.sv
package bank_dec_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned BANK_W = 3;

  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_RAM  = 2'd1,
    REG_IO   = 2'd2,
    REG_ROM  = 2'd3
  } region_e;
endpackage

// File: rtl/bank_hold.sv
module bank_hold #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BANK_W = 3
) (
  input  logic              phi2_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [BANK_W-1:0] bank_o
);
  logic [BANK_W-1:0] held_q;

  // capture at the instant the transparent phase ends
  always_ff @(posedge phi2_i or negedge rst_ni) begin
    if (!rst_ni) held_q <= '0;
    else         held_q <= data_i[BANK_W-1:0];
  end

  assign bank_o = phi2_i ? held_q : data_i[BANK_W-1:0];
endmodule

// File: rtl/map_decode.sv
module map_decode
  import bank_dec_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned BANK_W = 3,
  parameter int unsigned SLOW_W = 2,
  parameter int unsigned SUB_W  = 2,
  parameter logic [SUB_W-1:0] IO_SUB = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              valid_i,
  output region_e           region_o,
  output logic              wait_o
);
  localparam int unsigned SLOW_LSB = ADDR_W - SLOW_W;
  localparam int unsigned SUB_LSB  = SLOW_LSB - SUB_W;

  logic bank_zero;
  logic slow_win;
  logic io_hit;

  assign bank_zero = ~|bank_i;
  assign slow_win  = &addr_i[ADDR_W-1:SLOW_LSB];
  assign io_hit    = addr_i[SLOW_LSB-1:SUB_LSB] == IO_SUB;

  always_comb begin
    region_o = REG_NONE;
    if (valid_i) begin
      if (bank_zero && slow_win) region_o = io_hit ? REG_IO : REG_ROM;
      else                       region_o = REG_RAM;
    end
  end

  assign wait_o = valid_i & bank_zero & slow_win;
endmodule

// File: rtl/select_drive.sv
module select_drive
  import bank_dec_pkg::*;
(
  input  logic    phi2_i,
  input  logic    rwb_i,
  input  region_e region_i,
  output logic    ram_sel_o,
  output logic    io_sel_o,
  output logic    rom_sel_o,
  output logic    ram_rd_o,
  output logic    ram_wr_o
);
  assign ram_sel_o = region_i == REG_RAM;
  assign io_sel_o  = region_i == REG_IO;
  assign rom_sel_o = region_i == REG_ROM;
  assign ram_rd_o  = ram_sel_o & phi2_i & rwb_i;
  assign ram_wr_o  = ram_sel_o & phi2_i & ~rwb_i;
endmodule

// File: rtl/banked_addr_decoder.sv
module banked_addr_decoder
  import bank_dec_pkg::*;
(
  input  logic                phi2_i,
  input  logic                rst_ni,
  input  logic [DATA_W-1:0]   data_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                vda_i,
  input  logic                vpa_i,
  input  logic                rwb_i,
  output logic [BANK_W-1:0]   bank_o,
  output logic                ram_sel_o,
  output logic                io_sel_o,
  output logic                rom_sel_o,
  output logic                ram_rd_o,
  output logic                ram_wr_o,
  output logic                wait_req_o
);
  logic    valid;
  region_e region;

  assign valid = vda_i | vpa_i;

  bank_hold #(.DATA_W(DATA_W), .BANK_W(BANK_W)) u_hold (
    .phi2_i (phi2_i),
    .rst_ni (rst_ni),
    .data_i (data_i),
    .bank_o (bank_o)
  );

  map_decode #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_map (
    .addr_i   (addr_i),
    .bank_i   (bank_o),
    .valid_i  (valid),
    .region_o (region),
    .wait_o   (wait_req_o)
  );

  select_drive u_sel (
    .phi2_i    (phi2_i),
    .rwb_i     (rwb_i),
    .region_i  (region),
    .ram_sel_o (ram_sel_o),
    .io_sel_o  (io_sel_o),
    .rom_sel_o (rom_sel_o),
    .ram_rd_o  (ram_rd_o),
    .ram_wr_o  (ram_wr_o)
  );
endmodule

// File: rtl/banked_addr_decoder_chk.sv
module banked_addr_decoder_chk
  import bank_dec_pkg::*;
(
  input logic              phi2_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] data_i,
  input logic              vda_i,
  input logic              vpa_i,
  input logic [BANK_W-1:0] bank_o,
  input logic              ram_sel_o,
  input logic              io_sel_o,
  input logic              rom_sel_o,
  input logic              ram_rd_o,
  input logic              ram_wr_o,
  input logic              wait_req_o
);
  logic [BANK_W-1:0] cap_q;
  logic              armed_q;

  always_ff @(posedge phi2_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cap_q   <= data_i[BANK_W-1:0];
      armed_q <= 1'b1;
    end
  end

  AST_BANK_HOLD: assert property (@(negedge phi2_i) disable iff (!rst_ni)
    armed_q |-> bank_o == cap_q); // R2
  AST_SEL_ONEHOT: assert property (@(negedge phi2_i) disable iff (!rst_ni)
    $onehot0({ram_sel_o, io_sel_o, rom_sel_o})); // R12
  AST_INVALID_QUIET: assert property (@(negedge phi2_i) disable iff (!rst_ni)
    !(vda_i || vpa_i) |-> !(ram_sel_o || io_sel_o || rom_sel_o || wait_req_o || ram_rd_o || ram_wr_o)); // R10
  AST_EXT_BANK_RAM: assert property (@(negedge phi2_i) disable iff (!rst_ni)
    ((vda_i || vpa_i) && bank_o != '0) |-> (ram_sel_o && !io_sel_o && !rom_sel_o && !wait_req_o)); // R7
  AST_WAIT_SLOW: assert property (@(negedge phi2_i) disable iff (!rst_ni)
    wait_req_o |-> (io_sel_o || rom_sel_o)); // R9
  AST_STROBE_LOW_PHASE: assert property (@(posedge phi2_i) disable iff (!rst_ni)
    !ram_rd_o && !ram_wr_o); // R11
endmodule

bind banked_addr_decoder banked_addr_decoder_chk u_chk (
  .phi2_i     (phi2_i),
  .rst_ni     (rst_ni),
  .data_i     (data_i),
  .vda_i      (vda_i),
  .vpa_i      (vpa_i),
  .bank_o     (bank_o),
  .ram_sel_o  (ram_sel_o),
  .io_sel_o   (io_sel_o),
  .rom_sel_o  (rom_sel_o),
  .ram_rd_o   (ram_rd_o),
  .ram_wr_o   (ram_wr_o),
  .wait_req_o (wait_req_o)
);

// File: tb/banked_addr_decoder_tb_top.sv
`timescale 1ns/1ps
module banked_addr_decoder_tb_top;
  logic        phi2 = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  data = '0;
  logic [15:0] addr = '0;
  logic        vda = 1'b0;
  logic        vpa = 1'b0;
  logic        rwb = 1'b1;
  logic [2:0]  bank;
  logic        ram_sel, io_sel, rom_sel, ram_rd, ram_wr, wait_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 phi2 = ~phi2;

  banked_addr_decoder dut_i (
    .phi2_i(phi2), .rst_ni(rst_n), .data_i(data), .addr_i(addr),
    .vda_i(vda), .vpa_i(vpa), .rwb_i(rwb), .bank_o(bank),
    .ram_sel_o(ram_sel), .io_sel_o(io_sel), .rom_sel_o(rom_sel),
    .ram_rd_o(ram_rd), .ram_wr_o(ram_wr), .wait_req_o(wait_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one bus cycle: bank byte in low phase, junk on data in high phase
  task automatic bus_cycle(input logic [7:0] bb, input logic [15:0] a, input logic va,
                           input logic pa, input logic rw, input logic [7:0] junk,
                           input string tag);
    logic [2:0] bk;
    logic v, slow, b0, e_io, e_rom, e_ram, e_wait;
    bk = bb[2:0];
    v = va | pa;
    slow = a[15] & a[14];
    b0 = (bk == 3'd0);
    e_io = v & b0 & slow & (a[13:12] == 2'b00);
    e_rom = v & b0 & slow & (a[13:12] != 2'b00);
    e_ram = v & !(b0 & slow);
    e_wait = v & b0 & slow;
    @(negedge phi2);
    data = bb; addr = a; vda = va; vpa = pa; rwb = rw;
    #3;
    chk("R1 bank transparent in low phase", bank, bk);
    chk("R11 strobes low in low phase", {ram_rd, ram_wr}, 2'b00);
    @(posedge phi2);
    #2 data = junk;
    #3;
    chk("R2 bank held in high phase", bank, bk);
    chk({tag, " selects/wait"}, {ram_sel, io_sel, rom_sel, wait_req}, {e_ram, e_io, e_rom, e_wait});
    chk("R11 strobes in high phase", {ram_rd, ram_wr}, {e_ram & rw, e_ram & !rw});
    #4;
    chk("R12 wait stable in high phase", wait_req, e_wait);
    chk("R12 single select", 32'(ram_sel + io_sel + rom_sel) <= 1, 1);
  endtask

  task automatic t_reset();
    @(negedge phi2); data = 8'h05;
    @(posedge phi2); #3;
    chk("R3 bank zero in reset", bank, 3'd0);
    @(negedge phi2); rst_n = 1'b1;
  endtask

  task automatic t_bank0_ram();
    bus_cycle(8'h00, 16'h0000, 1, 0, 1, 8'hff, "R4");
    bus_cycle(8'h00, 16'hBFFF, 1, 0, 0, 8'h07, "R4");
    bus_cycle(8'h00, 16'h4000, 0, 1, 1, 8'h03, "R4");
  endtask

  task automatic t_io();
    bus_cycle(8'h00, 16'hC000, 1, 0, 1, 8'h07, "R5");
    bus_cycle(8'h00, 16'hC7FF, 1, 0, 0, 8'h01, "R5");
    bus_cycle(8'h00, 16'hC800, 1, 0, 1, 8'h05, "R5 mirror");
    bus_cycle(8'h00, 16'hCFFF, 1, 0, 1, 8'h02, "R5 mirror");
  endtask

  task automatic t_rom();
    bus_cycle(8'h00, 16'hD000, 0, 1, 1, 8'h06, "R6");
    bus_cycle(8'h00, 16'hFFFF, 1, 0, 1, 8'h07, "R6 R9");
    bus_cycle(8'h00, 16'hE123, 1, 1, 1, 8'h04, "R6");
  endtask

  task automatic t_ext_banks();
    for (int b = 1; b < 8; b++) begin
      bus_cycle(8'(b), 16'hC000, 1, 0, 1, 8'h00, "R7 io area");
      bus_cycle(8'(b), 16'hFFFF, 1, 0, 0, 8'h00, "R7 rom area");
    end
  endtask

  task automatic t_upper_ignored();
    bus_cycle(8'h08, 16'hD000, 1, 0, 1, 8'h01, "R8");
    bus_cycle(8'hF9, 16'hC400, 1, 0, 1, 8'h00, "R8");
  endtask

  task automatic t_invalid();
    bus_cycle(8'h00, 16'hC000, 0, 0, 1, 8'h00, "R10");
    bus_cycle(8'h03, 16'h1234, 0, 0, 0, 8'h00, "R10");
  endtask

  initial begin
    t_reset();
    t_bank0_ram();
    t_io();
    t_rom();
    t_ext_banks();
    t_upper_ignored();
    t_invalid();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule